// File: doc/BRIEF.md
# Three-Point Stencil Kernel With Tapped Output Delay Line

This block is the arithmetic core of a one-dimensional three-point averaging stencil that runs on a skewed, tiled schedule. Each cycle it takes one iteration slot. It adds three operands and scales the sum by one third with a fixed-point reciprocal. The result then passes down a shift-register line at the operator output. The three operands are not read from memory. They are taken from three fixed points on that line. An external scheduler orders the iterations so that the neighbours a result needs were produced exactly 5, 9 and 13 slots earlier. Intermediate values of a tile slice therefore live only in the pipeline and delay registers.

Slots that lie in padded regions of partial tiles are flagged as virtual. They still compute and still occupy a position in the delay line, so every tap distance stays constant. Their results never appear as valid output. At the edges of the spatial domain the scheduler raises a border select and supplies a boundary value. That value replaces the computed average, travels through the same pipeline, and so arrives with the correct delay for later iterations.

Top module: `stencil_tap_kernel`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `res_valid` is 0 and `res_data` is 0. Every pipeline and delay register starts at zero, so the first iterations see zero operands.
- R2: For a slot with `edge_sel`=0, the result equals (x5 + x9 + x13) / 3 rounded to nearest, within one LSB. Here xN is the result of the slot issued N slots earlier, and zero if no such slot exists since reset.
- R3: A slot issued at clock edge n is presented on `res_data`/`res_valid` during the cycle that follows edge n+LAT-1 (LAT=5). No valid result appears in the first LAT-1 cycles after reset.
- R4: For a slot with `edge_sel`=1, the result is exactly `edge_data` of that slot. This same value is the one later slots read through the taps.
- R5: A slot with `iter_virtual`=1 gives `res_valid`=0. Its dummy result is still computed and still occupies its place in the delay line.
- R6: A slot with `iter_valid`=0 is an idle slot. It gives `res_valid`=0, and the delay line still advances by one position, so the slot counts toward the tap distances.
- R7: Three full-scale operands (all ones, W=16) produce a full-scale result with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iter_valid | input | 1 | Slot carries an issued iteration |
| iter_virtual | input | 1 | Slot is a padded dummy iteration |
| edge_sel | input | 1 | Slot is a domain border; take `edge_data` as its result |
| edge_data | input | W | Boundary value used when `edge_sel` is 1 |
| res_valid | output | 1 | A real, valid result is presented |
| res_data | output | W | Result of the slot issued LAT edges earlier |

## Verification
A wrong register in the delay line or in the reciprocal stage does more than damage one result. The damaged value is fed back through the taps, so it surfaces on `res_data` within 5 to 13 slots. It then spreads to every later non-border result, and a mismatch appears quickly. An off-by-one tap position shows up as an averaging of the wrong history, which a bench model with its own slot history flags within a few dozen slots of random border injections. A control-bit error in the virtual or idle handling appears at `res_valid` exactly LAT cycles after the offending slot.

// File: rtl/stencil_tap_pkg.sv
package stencil_tap_pkg;

    // Control bits that travel alongside each slot through the operator.
    typedef struct packed {
        logic live;   // slot carries an issued iteration
        logic virt;   // padded dummy iteration
        logic brd;    // border slot: result taken from boundary value
    } slot_ctl_t;

    // Smallest integer not below 2^frac / 3 (2^frac is never a multiple of 3).
    function automatic longint unsigned third_recip(input int frac);
        return ((64'd1 << frac) + 64'd2) / 64'd3;
    endfunction

endpackage

// File: rtl/stencil_avg_pipe.sv
module stencil_avg_pipe
    import stencil_tap_pkg::*;
#(
    parameter int W   = 16,
    parameter int LAT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  slot_ctl_t       in_ctl,
    input  logic [W-1:0]    in_bq,
    input  logic [W-1:0]    opnd_near,
    input  logic [W-1:0]    opnd_mid,
    input  logic [W-1:0]    opnd_far,
    output slot_ctl_t       out_ctl,
    output logic [W-1:0]    out_bq,
    output logic [W-1:0]    out_avg
);
    localparam int SW   = W + 2;          // sum of three W-bit values
    localparam int FRAC = W + 4;          // reciprocal fraction bits
    localparam int PW   = SW + FRAC;      // product width
    localparam int RW   = LAT - 2;        // result stages after sum and product
    localparam logic [PW-1:0] RECIP = PW'(third_recip(FRAC));
    localparam logic [PW-1:0] HALF  = PW'(1) << (FRAC - 1);

    typedef struct packed {
        slot_ctl_t      ctl;
        logic [W-1:0]   bq;
        logic [SW-1:0]  sum;
    } sum_st_t;

    typedef struct packed {
        slot_ctl_t      ctl;
        logic [W-1:0]   bq;
        logic [PW-1:0]  prod;
    } mul_st_t;

    typedef struct packed {
        slot_ctl_t      ctl;
        logic [W-1:0]   bq;
        logic [W-1:0]   avg;
    } res_st_t;

    typedef struct packed {
        sum_st_t                s0;
        mul_st_t                s1;
        res_st_t [RW-1:0]       r;
    } pipe_t;

    pipe_t          pipe_d, pipe_q;
    logic [PW-1:0]  scaled;

    always_comb begin
        pipe_d = pipe_q;

        // Stage 0: three-operand add, control captured with the slot.
        pipe_d.s0.ctl = in_ctl;
        pipe_d.s0.bq  = in_bq;
        pipe_d.s0.sum = SW'(opnd_near) + SW'(opnd_mid) + SW'(opnd_far);

        // Stage 1: multiply by the rounded reciprocal, add rounding half.
        pipe_d.s1.ctl  = pipe_q.s0.ctl;
        pipe_d.s1.bq   = pipe_q.s0.bq;
        pipe_d.s1.prod = PW'(pipe_q.s0.sum) * RECIP + HALF;

        // Stage 2: drop the fraction.
        scaled            = pipe_q.s1.prod >> FRAC;
        pipe_d.r[0].ctl   = pipe_q.s1.ctl;
        pipe_d.r[0].bq    = pipe_q.s1.bq;
        pipe_d.r[0].avg   = scaled[W-1:0];

        // Remaining stages pad the operator out to LAT.
        for (int k = 1; k < RW; k++) begin
            pipe_d.r[k] = pipe_q.r[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_ctl = pipe_q.r[RW-1].ctl;
    assign out_bq  = pipe_q.r[RW-1].bq;
    assign out_avg = pipe_q.r[RW-1].avg;

    // The quotient never needs more than W bits.
    AST_QUOT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (scaled >> W) == '0);                                          // R7

    // The first rounded stage lies within one of a third of the sum two edges back.
    AST_QUOT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((SW+2)'(pipe_q.r[0].avg) * (SW+2)'(3) + (SW+2)'(2) >= (SW+2)'($past(pipe_q.s0.sum, 2)))
        && ((SW+2)'(pipe_q.r[0].avg) * (SW+2)'(3) <= (SW+2)'($past(pipe_q.s0.sum, 2)) + (SW+2)'(2))); // R2

endmodule

// File: rtl/stencil_border_sel.sv
module stencil_border_sel
    import stencil_tap_pkg::*;
#(
    parameter int W = 16
) (
    input  slot_ctl_t       ctl,
    input  logic [W-1:0]    bq,
    input  logic [W-1:0]    avg,
    output logic [W-1:0]    op_out
);
    // Border slots forward the boundary value in place of the average.
    always_comb begin
        op_out = avg;
        if (ctl.brd) begin
            op_out = bq;
        end
    end
endmodule

// File: rtl/stencil_tap_chain.sv
module stencil_tap_chain #(
    parameter int W       = 16,
    parameter int LEN     = 8,
    parameter int MID_IDX = 3,
    parameter int FAR_IDX = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    head,
    output logic [W-1:0]    first_q,
    output logic [W-1:0]    tap_mid,
    output logic [W-1:0]    tap_far
);
    localparam int NTAP = 2;

    typedef struct packed {
        logic [LEN-1:0][W-1:0] d;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d.d[0] = head;
        for (int k = 1; k < LEN; k++) begin
            chain_d.d[k] = chain_q.d[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    logic [NTAP-1:0][W-1:0] taps;

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        localparam int IDX = (t == 0) ? MID_IDX : FAR_IDX;
        assign taps[t] = chain_q.d[IDX];
    end

    assign first_q = chain_q.d[0];
    assign tap_mid = taps[0];
    assign tap_far = taps[1];
endmodule

// File: rtl/stencil_tap_kernel.sv
module stencil_tap_kernel
    import stencil_tap_pkg::*;
#(
    parameter int W        = 16,
    parameter int LAT      = 5,
    parameter int DIST_MID = 9,
    parameter int DIST_FAR = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iter_valid,
    input  logic            iter_virtual,
    input  logic            edge_sel,
    input  logic [W-1:0]    edge_data,
    output logic            res_valid,
    output logic [W-1:0]    res_data
);
    localparam int LEN     = DIST_FAR - LAT;
    localparam int MID_IDX = DIST_MID - LAT - 1;
    localparam int FAR_IDX = DIST_FAR - LAT - 1;
    localparam int CW      = $clog2(LAT + 1);

    slot_ctl_t      in_ctl, out_ctl;
    logic [W-1:0]   out_bq, out_avg, op_out;
    logic [W-1:0]   first_q, tap_mid, tap_far;
    logic [CW-1:0]  fill_d, fill_q;

    always_comb begin
        in_ctl.live = iter_valid;
        in_ctl.virt = iter_virtual;
        in_ctl.brd  = edge_sel;
    end

    // The nearest operand is the operator output itself: distance LAT.
    stencil_avg_pipe #(.W(W), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_ctl    (in_ctl),
        .in_bq     (edge_data),
        .opnd_near (op_out),
        .opnd_mid  (tap_mid),
        .opnd_far  (tap_far),
        .out_ctl   (out_ctl),
        .out_bq    (out_bq),
        .out_avg   (out_avg)
    );

    stencil_border_sel #(.W(W)) u_bsel (
        .ctl    (out_ctl),
        .bq     (out_bq),
        .avg    (out_avg),
        .op_out (op_out)
    );

    stencil_tap_chain #(.W(W), .LEN(LEN), .MID_IDX(MID_IDX), .FAR_IDX(FAR_IDX)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .head    (op_out),
        .first_q (first_q),
        .tap_mid (tap_mid),
        .tap_far (tap_far)
    );

    assign res_valid = out_ctl.live & ~out_ctl.virt;
    assign res_data  = op_out;

    // Edges since reset, saturating at LAT; guards the fill window.
    always_comb begin
        fill_d = fill_q;
        if (fill_q != CW'(LAT)) begin
            fill_d = fill_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!res_valid && res_data == '0));              // R1

    AST_FILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q < CW'(LAT)) |-> !res_valid);                            // R3

    AST_BORDER_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_ctl.brd) |-> (first_q == $past(out_bq)));            // R4

endmodule

// File: tb/sim_stencil_tap_kernel.sv
`timescale 1ns/1ps
module sim_stencil_tap_kernel;
    localparam int W    = 16;
    localparam int LAT  = 5;
    localparam int NCYC = 3000;
    localparam int FULL = (1 << W) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           iter_valid = 1'b0;
    logic           iter_virtual = 1'b0;
    logic           edge_sel = 1'b0;
    logic [W-1:0]   edge_data = '0;
    logic           res_valid;
    logic [W-1:0]   res_data;

    int unsigned compared = 0;
    int unsigned mismatched = 0;
    bit          done = 0;

    int unsigned h_val [NCYC];
    bit          h_live [NCYC];
    bit          h_virt [NCYC];
    bit          h_brd  [NCYC];

    always #5 clk = ~clk;

    stencil_tap_kernel #(.W(W), .LAT(LAT), .DIST_MID(9), .DIST_FAR(13)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .iter_valid   (iter_valid),
        .iter_virtual (iter_virtual),
        .edge_sel     (edge_sel),
        .edge_data    (edge_data),
        .res_valid    (res_valid),
        .res_data     (res_data)
    );

    function automatic int unsigned hist(input int n);
        return (n < 0) ? 0 : h_val[n];
    endfunction

    // R2: nearest rounding of the three-tap average.
    function automatic int unsigned model_avg(input int n);
        return (hist(n - 5) + hist(n - 9) + hist(n - 13) + 1) / 3;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        // R1: held in reset
        check(res_valid == 1'b0, "R1", int'(res_valid), 0);
        check(res_data == '0, "R1", int'(res_data), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NCYC; k++) begin
            @(negedge clk);
            // Observe the slot issued LAT edges ago.
            if (k == 0) begin
                check(res_valid == 1'b0, "R1", int'(res_valid), 0);
                check(res_data == '0, "R1", int'(res_data), 0);
            end else if (k < LAT) begin
                check(res_valid == 1'b0, "R3", int'(res_valid), 0);
                check(res_data == '0, "R3", int'(res_data), 0);
            end else begin
                int n;
                int unsigned ev;
                bit evld;
                string tag_d;
                string tag_v;
                int diff;
                n    = k - LAT;
                ev   = h_val[n];
                evld = h_live[n] && !h_virt[n];
                if (h_brd[n])              tag_d = "R4";
                else if (ev == FULL)       tag_d = "R7";
                else if (h_virt[n])        tag_d = "R5";
                else if (!h_live[n])       tag_d = "R6";
                else                       tag_d = "R2";
                if (h_virt[n])             tag_v = "R5";
                else if (!h_live[n])       tag_v = "R6";
                else                       tag_v = "R3";
                check(res_valid == evld, tag_v, int'(res_valid), int'(evld));
                diff = int'(res_data) - int'(ev);
                if (h_brd[n])
                    check(diff == 0, tag_d, int'(res_data), int'(ev));
                else
                    check(diff <= 1 && diff >= -1, tag_d, int'(res_data), int'(ev));
            end

            // Drive slot k.
            if (k < 24) begin
                iter_valid = 1'b1; iter_virtual = 1'b0; edge_sel = 1'b1; edge_data = W'(FULL);
            end else if (k < 60) begin
                iter_valid = 1'b1; iter_virtual = 1'b0; edge_sel = 1'b0; edge_data = W'($urandom);
            end else if (k < 80) begin
                iter_valid = 1'b1; iter_virtual = 1'b0; edge_sel = 1'b1; edge_data = '0;
            end else if (k == 80) begin
                iter_valid = 1'b1; iter_virtual = 1'b0; edge_sel = 1'b1; edge_data = W'(16'h3000);
            end else if (k < 120) begin
                iter_valid = (k % 7) != 0; iter_virtual = (k % 5) == 0;
                edge_sel = 1'b0; edge_data = W'($urandom);
            end else begin
                iter_valid   = ($urandom % 10) != 0;
                iter_virtual = ($urandom % 8) == 0;
                edge_sel     = ($urandom % 6) == 0;
                edge_data    = W'($urandom);
            end
            h_live[k] = iter_valid;
            h_virt[k] = iter_virtual;
            h_brd[k]  = edge_sel;
            h_val[k]  = edge_sel ? int'(edge_data) : model_avg(k);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule